// File: doc/BRIEF.md
# Operand Shifter with Carry Output

This block forms the second ALU operand of a 32-bit load/store processor datapath, together with the carry the shifter produces. It takes the instruction word, the value of the register being shifted, the value of the register that may supply a shift amount, the current carry flag and an immediate-operand select. It returns the shifted operand and the shifter carry in the same cycle. It is purely combinational. There is no handshake and no back-pressure. The operand and carry are valid as soon as the inputs settle, and the surrounding pipeline stage registers them.

Two operand forms are supported. In the immediate-operand form, an 8-bit constant is rotated right by an even amount. In the register form, the operand register is shifted by one of four shift kinds, by an amount taken either from the instruction or from a register. The exact results at amounts of 0, 32 and above 32 depend on the shift kind and on where the amount came from. These edge cases are the main purpose of the block.

Register-file reads, flag writeback and the ALU are outside this block. Instruction bits 3:0 (the operand register address) and bits 31:12 are not used here.

Top module: `opshift_core`

## Requirements
- R1: When the immediate-operand select is 0, instruction bit 4 picks the amount source. If bit 4 is 1, the amount is the low 8 bits of `amt_val`, and its upper bits have no effect. If bit 4 is 0, the amount is the 5-bit field in instruction bits 11:7, and `amt_val` has no effect.
- R2: Instruction bits 6:5 pick the shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R3: With `use_imm`=1, the operand is instruction bits 7:0, zero-extended and rotated right by twice the value in bits 11:8. The carry is `carry_in` when bits 11:8 are 0, and the operand's bit 31 otherwise.
- R4: Logical left by n in 1..31 gives `src_val << n`, with carry equal to `src_val` bit (32-n).
- R5: Logical left by exactly 32 gives 0 with carry equal to `src_val` bit 0. Logical left by more than 32 gives 0 with carry 0.
- R6: A register-sourced amount of 0, for any kind, passes `src_val` through with `carry_out` = `carry_in`. An immediate-encoded logical left by 0 does the same.
- R7: Logical right by n in 1..31 gives the zero-filled shift, with carry equal to bit n-1. An amount of 32, or an immediate-encoded 0, gives 0 with carry equal to bit 31. An amount above 32 gives 0 with carry 0.
- R8: Arithmetic right by n in 1..31 fills with bit 31, with carry equal to bit n-1. An amount of 32 or more, or an immediate-encoded 0, gives 32 copies of bit 31, with carry equal to bit 31.
- R9: Rotate right by a nonzero amount rotates by the amount modulo 32, with carry equal to the operand's bit 31. A register amount of 32 or 64 therefore returns `src_val` with carry equal to bit 31.
- R10: Rotate right with an immediate-encoded amount of 0 rotates right by one through the carry. The result is `{carry_in, src_val[31:1]}` and the carry is `src_val` bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 32 | Instruction word: amount, kind, source and immediate fields |
| src_val | input | DATA_W | Value of the register being shifted |
| amt_val | input | DATA_W | Value of the register that may supply the shift amount |
| carry_in | input | 1 | Current carry flag |
| use_imm | input | 1 | 1 selects the rotated 8-bit immediate operand form |
| operand | output | DATA_W | Shifted second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its defaults, DATA_W=32 and AMT_W=8. With these values, register-sourced amounts run from 0 up to 255, so the 32 boundary and the region above it can be reached for every shift kind. The 5-bit immediate field reaches only 0..31, so its reinterpreted zero is tested on its own. Hand-computed vectors cover each edge case. A sweep then compares every kind, both amount sources and amounts 0 to 40 against a bit-serial model. Garbage is placed in the `amt_val` bits that should be ignored. A second sweep covers all sixteen immediate rotations.

// File: rtl/opshift_pkg.sv
package opshift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  localparam int IMM_AMT_W  = 5;
  localparam int IMM_BYTE_W = 8;
  localparam int IMM_ROT_W  = 4;
endpackage

// File: rtl/opshift_amount.sv
module opshift_amount
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic                 from_reg,
  input  logic [IMM_AMT_W-1:0] imm_amt,
  input  shift_kind_e          kind,
  input  logic [AMT_W-1:0]     reg_amt,
  output logic [AMT_W-1:0]     amt_eff,
  output logic                 pass_thru,
  output logic                 rrx_mode
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic imm_zero;

  always_comb begin
    imm_zero  = (imm_amt == '0);
    pass_thru = from_reg ? (reg_amt == '0) : (imm_zero && kind == SH_LSL);
    rrx_mode  = !from_reg && imm_zero && kind == SH_ROR;
    if (from_reg)      amt_eff = reg_amt;
    else if (imm_zero) amt_eff = FULL_AMT;
    else               amt_eff = AMT_W'(imm_amt);
    // R6 / R10: pass-through and rotate-through-carry never both apply
    assert_mode_excl_R6: assert (!(pass_thru && rrx_mode))
      else $error("pass-through and rrx both active");
  end
endmodule

// File: rtl/opshift_left.sv
module opshift_left #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] v,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic [DATA_W:0] wide;

  always_comb begin
    wide = {1'b0, v} << amt;
    res  = wide[DATA_W-1:0];
    cout = wide[DATA_W];
    if (amt > FULL_AMT) begin
      assert_lsl_far_R5: assert (res == '0 && cout == 1'b0)
        else $error("left shift beyond width not cleared");
    end
    if (amt == FULL_AMT) begin
      assert_lsl_full_R5: assert (res == '0 && cout == v[0])
        else $error("left shift by width wrong carry");
    end
  end
endmodule

// File: rtl/opshift_right.sv
module opshift_right #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  parameter bit ARITH  = 1'b0
) (
  input  logic [DATA_W-1:0] v,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic [DATA_W:0] wide;

  generate
    if (ARITH) begin : g_arith
      always_comb begin
        wide = $signed({v, 1'b0}) >>> amt;
        res  = wide[DATA_W:1];
        cout = wide[0];
        if (amt >= FULL_AMT) begin
          assert_asr_far_R8: assert (res == {DATA_W{v[DATA_W-1]}} && cout == v[DATA_W-1])
            else $error("arithmetic shift beyond width not sign-filled");
        end
      end
    end else begin : g_logic
      always_comb begin
        wide = {v, 1'b0} >> amt;
        res  = wide[DATA_W:1];
        cout = wide[0];
        if (amt > FULL_AMT) begin
          assert_lsr_far_R7: assert (res == '0 && cout == 1'b0)
            else $error("logical right beyond width not cleared");
        end
        if (amt == FULL_AMT) begin
          assert_lsr_full_R7: assert (res == '0 && cout == v[DATA_W-1])
            else $error("logical right by width wrong carry");
        end
      end
    end
  endgenerate
endmodule

// File: rtl/opshift_rotate.sv
module opshift_rotate
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         v,
  input  logic [$clog2(DATA_W)-1:0] k,
  input  logic                      cin,
  input  logic                      rrx,
  input  logic                      use_imm,
  input  logic [IMM_BYTE_W-1:0]     imm_byte,
  input  logic [IMM_ROT_W-1:0]      imm_rot,
  output logic [DATA_W-1:0]         res,
  output logic                      cout
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0]   src;
  logic [SH_W-1:0]     kk;
  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0]   rot;

  always_comb begin
    src = use_imm ? DATA_W'(imm_byte) : v;
    kk  = use_imm ? SH_W'({imm_rot, 1'b0}) : k;
    dbl = {src, src} >> kk;
    rot = dbl[DATA_W-1:0];
    if (rrx && !use_imm) begin
      res  = {cin, v[DATA_W-1:1]};
      cout = v[0];
    end else begin
      res  = rot;
      cout = (use_imm && imm_rot == '0) ? cin : rot[DATA_W-1];
    end
    if (use_imm) begin
      assert_imm_bits_R3: assert ($countones(res) == $countones(imm_byte))
        else $error("immediate rotation lost bits");
    end else if (!rrx) begin
      assert_ror_bits_R9: assert ($countones(res) == $countones(v))
        else $error("rotation lost bits");
    end else begin
      assert_rrx_carry_R10: assert (cout == v[0] && res[DATA_W-1] == cin)
        else $error("rotate through carry wrong");
    end
  end
endmodule

// File: rtl/opshift_core.sv
module opshift_core
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [31:0]       instr_word,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] amt_val,
  input  logic              carry_in,
  input  logic              use_imm,
  output logic [DATA_W-1:0] operand,
  output logic              carry_out
);
  localparam int SH_W = $clog2(DATA_W);

  shift_kind_e       kind;
  logic [AMT_W-1:0]  amt_eff;
  logic              pass_thru;
  logic              rrx_mode;
  logic [DATA_W-1:0] lsl_res, lsr_res, asr_res, ror_res;
  logic              lsl_c, lsr_c, asr_c, ror_c;
  logic              unused_bits;

  assign kind        = shift_kind_e'(instr_word[6:5]);
  assign unused_bits = ^{instr_word[31:12], amt_val[DATA_W-1:AMT_W]};

  opshift_amount #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amount (
    .from_reg (instr_word[4]),
    .imm_amt  (instr_word[11:7]),
    .kind     (kind),
    .reg_amt  (amt_val[AMT_W-1:0]),
    .amt_eff  (amt_eff),
    .pass_thru(pass_thru),
    .rrx_mode (rrx_mode)
  );

  opshift_left #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_lsl (
    .v(src_val), .amt(amt_eff), .res(lsl_res), .cout(lsl_c)
  );

  opshift_right #(.DATA_W(DATA_W), .AMT_W(AMT_W), .ARITH(1'b0)) u_lsr (
    .v(src_val), .amt(amt_eff), .res(lsr_res), .cout(lsr_c)
  );

  opshift_right #(.DATA_W(DATA_W), .AMT_W(AMT_W), .ARITH(1'b1)) u_asr (
    .v(src_val), .amt(amt_eff), .res(asr_res), .cout(asr_c)
  );

  opshift_rotate #(.DATA_W(DATA_W)) u_ror (
    .v       (src_val),
    .k       (amt_eff[SH_W-1:0]),
    .cin     (carry_in),
    .rrx     (rrx_mode),
    .use_imm (use_imm),
    .imm_byte(instr_word[7:0]),
    .imm_rot (instr_word[11:8]),
    .res     (ror_res),
    .cout    (ror_c)
  );

  always_comb begin
    if (use_imm) begin
      operand   = ror_res;
      carry_out = ror_c;
    end else if (pass_thru) begin
      operand   = src_val;
      carry_out = carry_in;
    end else begin
      unique case (kind)
        SH_LSL:  begin operand = lsl_res; carry_out = lsl_c; end
        SH_LSR:  begin operand = lsr_res; carry_out = lsr_c; end
        SH_ASR:  begin operand = asr_res; carry_out = asr_c; end
        default: begin operand = ror_res; carry_out = ror_c; end
      endcase
    end
    if (!use_imm && instr_word[4] && amt_val[7:0] == 8'd0) begin
      assert_reg_zero_pass_R6: assert (operand == src_val && carry_out == carry_in)
        else $error("zero register amount altered operand");
    end
  end
endmodule

// File: tb/tb_opshift_core.sv
module tb_opshift_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_word, src_val, amt_val;
  logic        carry_in, use_imm;
  logic [31:0] operand;
  logic        carry_out;
  int          nchecks = 0;
  int          nfail = 0;

  always #4 clk = ~clk;

  opshift_core dut (
    .instr_word(instr_word), .src_val(src_val), .amt_val(amt_val),
    .carry_in(carry_in), .use_imm(use_imm),
    .operand(operand), .carry_out(carry_out)
  );

  typedef struct packed {
    logic        imm;
    logic [31:0] ins;
    logic [31:0] val;
    logic [31:0] amt;
    logic        cin;
    logic [31:0] res;
    logic        c;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h200, 32'h8000_0001, 32'h0,   1'b1, 32'h0000_0010, 1'b0}, // R4 lsl imm 4
    '{1'b0, 32'h080, 32'h8000_0000, 32'h0,   1'b0, 32'h0000_0000, 1'b1}, // R4 lsl imm 1
    '{1'b0, 32'h220, 32'h0000_00F8, 32'h0,   1'b0, 32'h0000_000F, 1'b1}, // R7 lsr imm 4
    '{1'b0, 32'h020, 32'h8000_0000, 32'h0,   1'b0, 32'h0000_0000, 1'b1}, // R7 lsr imm 0 = 32
    '{1'b0, 32'h240, 32'h8000_0000, 32'h0,   1'b1, 32'hF800_0000, 1'b0}, // R8 asr imm 4
    '{1'b0, 32'h040, 32'h8000_0000, 32'h0,   1'b0, 32'hFFFF_FFFF, 1'b1}, // R8 asr imm 0
    '{1'b0, 32'h460, 32'h1234_5678, 32'h0,   1'b1, 32'h7812_3456, 1'b0}, // R9 ror imm 8
    '{1'b0, 32'h060, 32'h0000_0003, 32'h0,   1'b1, 32'h8000_0001, 1'b1}, // R10 rrx
    '{1'b0, 32'h010, 32'h0000_0001, 32'd32,  1'b0, 32'h0000_0000, 1'b1}, // R5 lsl reg 32
    '{1'b0, 32'h010, 32'h0000_0001, 32'd33,  1'b1, 32'h0000_0000, 1'b0}, // R5 lsl reg 33
    '{1'b0, 32'h030, 32'h8000_0000, 32'd32,  1'b0, 32'h0000_0000, 1'b1}, // R7 lsr reg 32
    '{1'b0, 32'h030, 32'h8000_0000, 32'd40,  1'b1, 32'h0000_0000, 1'b0}, // R7 lsr reg 40
    '{1'b0, 32'h050, 32'h8000_0000, 32'd200, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R8 asr reg 200
    '{1'b0, 32'h070, 32'h1234_5678, 32'd36,  1'b0, 32'h8123_4567, 1'b1}, // R9 ror reg 36
    '{1'b0, 32'h070, 32'h8000_0000, 32'd32,  1'b0, 32'h8000_0000, 1'b1}, // R9 ror reg 32
    '{1'b0, 32'h030, 32'h0000_0005, 32'h100, 1'b1, 32'h0000_0005, 1'b1}, // R1 R6 upper amt bits ignored
    '{1'b1, 32'h1FF, 32'hDEAD_BEEF, 32'h0,   1'b0, 32'hC000_003F, 1'b1}, // R3 imm rot 1
    '{1'b1, 32'h080, 32'hDEAD_BEEF, 32'h0,   1'b1, 32'h0000_0080, 1'b1}, // R3 imm rot 0
    '{1'b0, 32'h000, 32'h0000_ABCD, 32'h5,   1'b0, 32'h0000_ABCD, 1'b0}  // R2 R6 lsl imm 0
  };

  function automatic void ref_model(input logic imm, input logic [31:0] ins,
                                    input logic [31:0] val, input logic [31:0] amt,
                                    input logic cin, output logic [31:0] r, output logic c);
    int n;
    logic [1:0] t;
    r = val;
    c = cin;
    if (imm) begin
      r = {24'b0, ins[7:0]};
      for (int i = 0; i < 2 * int'(ins[11:8]); i++) r = {r[0], r[31:1]};
      if (ins[11:8] != 4'd0) c = r[31];
      return;
    end
    t = ins[6:5];
    n = ins[4] ? int'(amt[7:0]) : int'(ins[11:7]);
    if (!ins[4] && n == 0) begin
      if (t == 2'b01 || t == 2'b10) n = 32;
      if (t == 2'b11) begin
        c = val[0];
        r = {cin, val[31:1]};
        return;
      end
    end
    for (int i = 0; i < n; i++) begin
      case (t)
        2'b00: begin c = r[31]; r = r << 1; end
        2'b01: begin c = r[0];  r = r >> 1; end
        2'b10: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endfunction

  task automatic apply(input logic imm, input logic [31:0] ins, input logic [31:0] val,
                       input logic [31:0] amt, input logic cin);
    @(negedge clk);
    use_imm = imm; instr_word = ins; src_val = val; amt_val = amt; carry_in = cin;
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic ec);
    nchecks++;
    if (operand !== er || carry_out !== ec) begin
      nfail++;
      $display("FAIL %s: operand=%h expected %h, carry=%b expected %b",
               tag, operand, er, carry_out, ec);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog (R1..R10 unfinished): actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    logic [31:0] er;
    logic        ec;
    logic [31:0] vals [3];
    vals[0] = 32'h8000_0001; vals[1] = 32'h1234_5678; vals[2] = 32'hF0F0_0F0F;

    // reset-time quiet inputs: lsl by immediate 0 of zero passes through (R6)
    apply(1'b0, 32'h0, 32'h0, 32'h0, 1'b0);
    check("R6 reset quiet inputs", 32'h0, 1'b0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // table of hand-worked vectors
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].imm, VECS[i].ins, VECS[i].val, VECS[i].amt, VECS[i].cin);
      check($sformatf("R2 table vector %0d", i), VECS[i].res, VECS[i].c);
    end

    // sweep all kinds, both amount sources (R1) against the bit-serial model
    for (int t = 0; t < 4; t++) begin
      for (int src = 0; src < 2; src++) begin
        for (int n = 0; n <= (src == 1 ? 40 : 31); n++) begin
          for (int vi = 0; vi < 3; vi++) begin
            logic [31:0] ins, amt;
            string tag;
            ins = {20'b0, (src == 1) ? 5'd0 : 5'(n), 2'(t), 1'(src), 4'b0};
            amt = (src == 1) ? (32'hFFFF_FF00 | 32'(n)) : 32'h0000_0007;
            case (t)
              0: tag = "R1 R4 R5 lsl sweep";
              1: tag = "R1 R7 lsr sweep";
              2: tag = "R1 R8 asr sweep";
              default: tag = "R1 R9 R10 ror sweep";
            endcase
            apply(1'b0, ins, vals[vi], amt, 1'(n));
            ref_model(1'b0, ins, vals[vi], amt, 1'(n), er, ec);
            check($sformatf("%s n=%0d src=%0d", tag, n, src), er, ec);
          end
        end
      end
    end

    // immediate-operand form, every rotation (R3)
    for (int rot = 0; rot < 16; rot++) begin
      for (int b = 0; b < 2; b++) begin
        logic [31:0] ins;
        ins = {20'b0, 4'(rot), (b == 0) ? 8'hA5 : 8'h01};
        apply(1'b1, ins, 32'h5555_AAAA, 32'h1F, 1'(b));
        ref_model(1'b1, ins, 32'h5555_AAAA, 32'h1F, 1'(b), er, ec);
        check($sformatf("R3 imm rot=%0d", rot), er, ec);
      end
    end

    // directed corners: rrx with carry low (R10), reg zero amount on asr (R6)
    apply(1'b0, 32'h060, 32'hFFFF_FFFE, 32'h0, 1'b0);
    check("R10 rrx carry low", 32'h7FFF_FFFF, 1'b0);
    apply(1'b0, 32'h050, 32'h8000_0000, 32'hABCD_EF00, 1'b0);
    check("R6 asr reg amount 0", 32'h8000_0000, 1'b0);
    apply(1'b0, 32'h010, 32'h0000_0003, 32'd31, 1'b0);
    check("R4 lsl reg 31", 32'h8000_0000, 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule